// File: doc/BRIEF.md
# DDR2 Mode Register Capture and Decode

This block sits on the device side of a DDR2 memory. It watches the registered command bus on every rising clock edge and picks out mode-register-set commands aimed at the base mode register or at one of the three extended mode registers. Accepted writes update a small set of stored configuration fields. The block then presents these fields as decoded values: CAS latency, burst length, additive latency, read-strobe and data-mask enables, and the output-driver calibration state.

Every write is screened before it is stored. A write is refused if the clock enable is low, if any bank is still open, if the write carries an encoding that has no meaning, or if it sets a reserved address bit. A refused write changes nothing, and the block raises a one-cycle error flag. When the calibration field selects a drive mode, the block forces fixed levels onto the data and strobe pins so that an external tester can measure the output drivers.

Top module: `mrs_cfg_decoder`

## Requirements
- R1: A mode write is recognised only when cs_n, ras_n, cas_n and we_n are all 0 at a rising edge. Any other combination changes no output and leaves mrs_err at 0.
- R2: ba[1:0] picks the target register: 0 is the base mode register, 1 is extended register 1, 2 is extended register 2 and 3 is extended register 3. A write to register 2 is accepted and has no visible effect.
- R3: A recognised write with cke at 0 or all_idle at 0 is refused. It raises mrs_err and updates nothing.
- R4: In the base register, addr[2:0] gives the burst length: code 2 means 4 beats and code 3 means 8 beats. Any other code refuses the whole write and raises mrs_err.
- R5: In the base register, addr[6:4] gives the CAS latency, and codes 2 to 6 are legal. Any other code refuses the whole write and raises mrs_err.
- R6: Extended register 1 takes the additive latency from addr[5:3] and the read-strobe enable from addr[11]. dm_en is always the inverse of rdqs_en.
- R7: An extended register 1 write with ba[2] set or any of addr[15:13] set is refused with mrs_err. An extended register 3 write with ba[2] set or any address bit set is refused in the same way.
- R8: ocd_mode reports addr[9:7] of the last accepted extended register 1 write. Code 1 (drive high) sets force_en, force_dq and force_dqs, and clears force_dqs_n. Code 2 (drive low) sets force_en and force_dqs_n, and clears force_dq and force_dqs. Every other code clears all four force outputs.
- R9: An extended register 1 write whose addr[9:7] is 4 (adjust) leaves add_lat unchanged. While ocd_mode is 4, burst_len reads 4 whatever the stored length is.
- R10: After reset, mr_valid and emr1_valid are 0, the decoded values are 0, ocd_mode is 0 and dm_en is 1. burst_len is 0 while mr_valid is 0. Each valid flag goes to 1 on the first accepted write to its register and stays at 1.
- R11: mrs_err and every decoded output change one clock after the edge that samples the command. mrs_err is high for exactly that one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cke | input | 1 | Clock enable as registered by the device |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 3 | Bank address |
| addr | input | 16 | Address bus carrying the register contents |
| all_idle | input | 1 | High when every bank is precharged |
| cas_lat | output | 3 | Decoded CAS latency in clocks |
| burst_len | output | 4 | Effective burst length in beats (0 until set) |
| add_lat | output | 3 | Additive latency in clocks |
| mr_valid | output | 1 | Base register has been written |
| emr1_valid | output | 1 | Extended register 1 has been written |
| rdqs_en | output | 1 | Read data strobe enabled |
| dm_en | output | 1 | Data mask enabled |
| ocd_mode | output | 3 | Stored driver calibration code |
| force_en | output | 1 | Output pins are forced to a test pattern |
| force_dq | output | 1 | Forced level for the data pins |
| force_dqs | output | 1 | Forced level for the true strobe and read strobe |
| force_dqs_n | output | 1 | Forced level for the complementary strobe |
| mrs_err | output | 1 | One-cycle flag for a refused write |

## Verification
Every result is registered and appears one clock after the edge that samples the command: the error pulse, the stored fields, and the drive pattern and burst length derived from them. The bench applies each command half a cycle before an edge. It then compares every output at the following falling edge against a model that it updates arithmetically from the same command. As a result, each vector checks both that the command took effect and that the pulse from the previous vector has ended. The checker adds clocked properties that span exactly one edge, covering refusal, field retention and the stickiness of the valid flags.

// File: rtl/mrs_pkg.sv
package mrs_pkg;

    localparam int FLD_W    = 3;
    localparam int BL_LSB   = 0;
    localparam int CL_LSB   = 4;
    localparam int AL_LSB   = 3;
    localparam int OCD_LSB  = 7;
    localparam int RDQS_BIT = 11;
    localparam int RSV_LSB  = 13;

    localparam logic [FLD_W-1:0] BL_CODE_4 = 3'b010;
    localparam logic [FLD_W-1:0] BL_CODE_8 = 3'b011;
    localparam logic [FLD_W-1:0] CL_MIN    = 3'd2;
    localparam logic [FLD_W-1:0] CL_MAX    = 3'd6;

    localparam logic [FLD_W-1:0] OCD_EXIT  = 3'b000;
    localparam logic [FLD_W-1:0] OCD_DRV1  = 3'b001;
    localparam logic [FLD_W-1:0] OCD_DRV0  = 3'b010;
    localparam logic [FLD_W-1:0] OCD_ADJ   = 3'b100;

    typedef enum logic [1:0] {
        TGT_MR   = 2'b00,
        TGT_EMR1 = 2'b01,
        TGT_EMR2 = 2'b10,
        TGT_EMR3 = 2'b11
    } mrs_tgt_e;

    typedef struct packed {
        logic             accept;
        logic             err;
        mrs_tgt_e         tgt;
        logic [FLD_W-1:0] cl;
        logic             bl8;
        logic [FLD_W-1:0] al;
        logic             rdqs;
        logic [FLD_W-1:0] ocd;
    } mrs_req_t;

    typedef struct packed {
        logic             mr_v;
        logic             emr1_v;
        logic [FLD_W-1:0] cl;
        logic             bl8;
        logic [FLD_W-1:0] al;
        logic             rdqs;
        logic [FLD_W-1:0] ocd;
    } mrs_cfg_t;

    typedef struct packed {
        logic en;
        logic dq;
        logic dqs;
        logic dqs_n;
    } ocd_force_t;

    function automatic logic bl_code_ok(input logic [FLD_W-1:0] code);
        return (code == BL_CODE_4) || (code == BL_CODE_8);
    endfunction

    function automatic logic cl_code_ok(input logic [FLD_W-1:0] code);
        return (code >= CL_MIN) && (code <= CL_MAX);
    endfunction

endpackage

// File: rtl/mrs_cmd_decode.sv
module mrs_cmd_decode
    import mrs_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int BA_W   = 3
) (
    input  logic              cke,
    input  logic              cs_n,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic [BA_W-1:0]   ba,
    input  logic [ADDR_W-1:0] addr,
    input  logic              all_idle,
    output mrs_req_t          req
);

    logic hit;
    logic state_bad;
    logic field_bad;
    logic ba_hi_set;

    always_comb begin
        hit       = !cs_n && !ras_n && !cas_n && !we_n;
        state_bad = !cke || !all_idle;
        ba_hi_set = |ba[BA_W-1:2];
        req.tgt   = mrs_tgt_e'(ba[1:0]);

        unique case (req.tgt)
            TGT_MR:   field_bad = !bl_code_ok(addr[BL_LSB +: FLD_W])
                               || !cl_code_ok(addr[CL_LSB +: FLD_W]);
            TGT_EMR1: field_bad = ba_hi_set || (|addr[ADDR_W-1:RSV_LSB]);
            TGT_EMR2: field_bad = 1'b0;
            TGT_EMR3: field_bad = ba_hi_set || (|addr);
        endcase

        req.err    = hit && (state_bad || field_bad);
        req.accept = hit && !state_bad && !field_bad;
        req.cl     = addr[CL_LSB +: FLD_W];
        req.bl8    = (addr[BL_LSB +: FLD_W] == BL_CODE_8);
        req.al     = addr[AL_LSB +: FLD_W];
        req.rdqs   = addr[RDQS_BIT];
        req.ocd    = addr[OCD_LSB +: FLD_W];
    end

endmodule

// File: rtl/mrs_cfg_regs.sv
module mrs_cfg_regs
    import mrs_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  mrs_req_t req,
    output mrs_cfg_t cfg,
    output logic     err_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg   <= '0;
            err_q <= 1'b0;
        end else begin
            err_q <= req.err;
            if (req.accept) begin
                unique case (req.tgt)
                    TGT_MR: begin
                        cfg.cl   <= req.cl;
                        cfg.bl8  <= req.bl8;
                        cfg.mr_v <= 1'b1;
                    end
                    TGT_EMR1: begin
                        cfg.ocd    <= req.ocd;
                        cfg.rdqs   <= req.rdqs;
                        cfg.emr1_v <= 1'b1;
                        if (req.ocd != OCD_ADJ) begin
                            cfg.al <= req.al;
                        end
                    end
                    default: begin
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/mrs_ocd_drive.sv
module mrs_ocd_drive
    import mrs_pkg::*;
(
    input  logic [FLD_W-1:0] ocd,
    output ocd_force_t       frc
);

    logic hi;
    logic lo;

    always_comb begin
        hi        = (ocd == OCD_DRV1);
        lo        = (ocd == OCD_DRV0);
        frc.en    = hi || lo;
        frc.dq    = hi;
        frc.dqs   = hi;
        frc.dqs_n = lo;
    end

endmodule

// File: rtl/mrs_cfg_decoder.sv
module mrs_cfg_decoder
    import mrs_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int BA_W   = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cke,
    input  logic              cs_n,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic [BA_W-1:0]   ba,
    input  logic [ADDR_W-1:0] addr,
    input  logic              all_idle,
    output logic [2:0]        cas_lat,
    output logic [3:0]        burst_len,
    output logic [2:0]        add_lat,
    output logic              mr_valid,
    output logic              emr1_valid,
    output logic              rdqs_en,
    output logic              dm_en,
    output logic [2:0]        ocd_mode,
    output logic              force_en,
    output logic              force_dq,
    output logic              force_dqs,
    output logic              force_dqs_n,
    output logic              mrs_err
);

    mrs_req_t   req;
    mrs_cfg_t   cfg;
    ocd_force_t frc;

    mrs_cmd_decode #(.ADDR_W(ADDR_W), .BA_W(BA_W)) u_dec (
        .cke      (cke),
        .cs_n     (cs_n),
        .ras_n    (ras_n),
        .cas_n    (cas_n),
        .we_n     (we_n),
        .ba       (ba),
        .addr     (addr),
        .all_idle (all_idle),
        .req      (req)
    );

    mrs_cfg_regs u_regs (
        .clk   (clk),
        .rst   (rst),
        .req   (req),
        .cfg   (cfg),
        .err_q (mrs_err)
    );

    mrs_ocd_drive u_drv (
        .ocd (cfg.ocd),
        .frc (frc)
    );

    always_comb begin
        cas_lat    = cfg.cl;
        add_lat    = cfg.al;
        mr_valid   = cfg.mr_v;
        emr1_valid = cfg.emr1_v;
        rdqs_en    = cfg.rdqs;
        dm_en      = !cfg.rdqs;
        ocd_mode   = cfg.ocd;
        if (!cfg.mr_v)
            burst_len = 4'd0;
        else if (cfg.ocd == OCD_ADJ || !cfg.bl8)
            burst_len = 4'd4;
        else
            burst_len = 4'd8;
        force_en    = frc.en;
        force_dq    = frc.dq;
        force_dqs   = frc.dqs;
        force_dqs_n = frc.dqs_n;
    end

endmodule

// File: rtl/mrs_cfg_checker.sv
module mrs_cfg_checker #(
    parameter int ADDR_W = 16,
    parameter int BA_W   = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              cke,
    input logic              cs_n,
    input logic              ras_n,
    input logic              cas_n,
    input logic              we_n,
    input logic [BA_W-1:0]   ba,
    input logic [ADDR_W-1:0] addr,
    input logic              all_idle,
    input logic [2:0]        cas_lat,
    input logic [2:0]        add_lat,
    input logic              mr_valid,
    input logic              emr1_valid,
    input logic              force_en,
    input logic              mrs_err
);

    logic mode_cmd;
    assign mode_cmd = !cs_n && !ras_n && !cas_n && !we_n;

    assert_state_refused_R3: assert property (@(posedge clk) disable iff (rst)
        (mode_cmd && (!cke || !all_idle)) |=> mrs_err);

    assert_no_cmd_no_err_R1: assert property (@(posedge clk) disable iff (rst)
        !mode_cmd |=> !mrs_err);

    assert_bad_cl_kept_R5: assert property (@(posedge clk) disable iff (rst)
        (mode_cmd && ba[1:0] == 2'b00 && (addr[6:4] < 3'd2 || addr[6:4] > 3'd6))
        |=> (mrs_err && $stable(cas_lat)));

    assert_emr3_nonzero_R7: assert property (@(posedge clk) disable iff (rst)
        (mode_cmd && ba[1:0] == 2'b11 && addr != '0) |=> mrs_err);

    assert_adjust_keeps_al_R9: assert property (@(posedge clk) disable iff (rst)
        (mode_cmd && ba[1:0] == 2'b01 && addr[9:7] == 3'b100) |=> $stable(add_lat));

    assert_mr_valid_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        mr_valid |=> mr_valid);

    assert_emr1_valid_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        emr1_valid |=> emr1_valid);

    assert_force_needs_write_R8: assert property (@(posedge clk) disable iff (rst)
        force_en |-> emr1_valid);

endmodule

bind mrs_cfg_decoder mrs_cfg_checker #(.ADDR_W(ADDR_W), .BA_W(BA_W)) u_chk (.*);

// File: tb/sim_mrs_cfg_decoder.sv
module sim_mrs_cfg_decoder;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        cke, cs_n, ras_n, cas_n, we_n, all_idle;
    logic [2:0]  ba;
    logic [15:0] addr;
    logic [2:0]  cas_lat, add_lat, ocd_mode;
    logic [3:0]  burst_len;
    logic        mr_valid, emr1_valid, rdqs_en, dm_en;
    logic        force_en, force_dq, force_dqs, force_dqs_n, mrs_err;

    int n_vec  = 0;
    int n_fail = 0;

    logic       m_mrv, m_e1v, m_bl8, m_rdqs, e_err;
    logic [2:0] m_cl, m_al, m_ocd;

    always #(CLK_PERIOD/2) clk = ~clk;

    mrs_cfg_decoder u0 (
        .clk(clk), .rst(rst), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
        .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr), .all_idle(all_idle),
        .cas_lat(cas_lat), .burst_len(burst_len), .add_lat(add_lat),
        .mr_valid(mr_valid), .emr1_valid(emr1_valid), .rdqs_en(rdqs_en),
        .dm_en(dm_en), .ocd_mode(ocd_mode), .force_en(force_en),
        .force_dq(force_dq), .force_dqs(force_dqs), .force_dqs_n(force_dqs_n),
        .mrs_err(mrs_err)
    );

    task automatic chk(input string tag, input string name, input int got, input int exp);
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d", tag, name, got, exp);
        end
    endtask

    task automatic compare_all(input string tag);
        logic [3:0] e_bl;
        n_vec++;
        e_bl = !m_mrv ? 4'd0 : ((m_ocd == 3'd4 || !m_bl8) ? 4'd4 : 4'd8);
        chk(tag, "mrs_err",     mrs_err,     e_err);
        chk(tag, "cas_lat",     cas_lat,     m_cl);
        chk(tag, "burst_len",   burst_len,   e_bl);
        chk(tag, "add_lat",     add_lat,     m_al);
        chk(tag, "mr_valid",    mr_valid,    m_mrv);
        chk(tag, "emr1_valid",  emr1_valid,  m_e1v);
        chk(tag, "rdqs_en",     rdqs_en,     m_rdqs);
        chk(tag, "dm_en",       dm_en,       !m_rdqs);
        chk(tag, "ocd_mode",    ocd_mode,    m_ocd);
        chk(tag, "force_en",    force_en,    (m_ocd == 3'd1) || (m_ocd == 3'd2));
        chk(tag, "force_dq",    force_dq,    m_ocd == 3'd1);
        chk(tag, "force_dqs",   force_dqs,   m_ocd == 3'd1);
        chk(tag, "force_dqs_n", force_dqs_n, m_ocd == 3'd2);
    endtask

    // cmd = {cs_n, ras_n, cas_n, we_n}; called at a falling edge
    task automatic apply(input string tag, input bit cke_i, input bit idle_i,
                         input bit [3:0] cmd, input bit [2:0] ba_i, input bit [15:0] a_i);
        bit hit, bad;
        cke = cke_i; all_idle = idle_i;
        {cs_n, ras_n, cas_n, we_n} = cmd;
        ba = ba_i; addr = a_i;
        hit = (cmd == 4'b0000);
        bad = !cke_i || !idle_i;
        case (ba_i[1:0])
            2'd0: bad = bad || !(a_i[2:0] == 3'd2 || a_i[2:0] == 3'd3)
                            || a_i[6:4] < 3'd2 || a_i[6:4] > 3'd6;
            2'd1: bad = bad || ba_i[2] || (a_i[15:13] != 3'd0);
            2'd3: bad = bad || ba_i[2] || (a_i != 16'd0);
            default: ;
        endcase
        e_err = hit && bad;
        if (hit && !bad) begin
            if (ba_i[1:0] == 2'd0) begin
                m_cl = a_i[6:4]; m_bl8 = (a_i[2:0] == 3'd3); m_mrv = 1'b1;
            end else if (ba_i[1:0] == 2'd1) begin
                m_ocd = a_i[9:7]; m_rdqs = a_i[11]; m_e1v = 1'b1;
                if (a_i[9:7] != 3'd4) m_al = a_i[5:3];
            end
        end
        @(posedge clk);
        @(negedge clk);
        compare_all(tag);
    endtask

    task automatic nop(input string tag);
        apply(tag, 1'b1, 1'b1, 4'b1111, 3'd0, 16'd0);
    endtask

    initial begin
        for (int c = 0; c < 20000; c++) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1; cke = 1'b1; all_idle = 1'b1;
        {cs_n, ras_n, cas_n, we_n} = 4'b1111; ba = '0; addr = '0;
        {m_mrv, m_e1v, m_bl8, m_rdqs, e_err} = '0;
        m_cl = '0; m_al = '0; m_ocd = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        compare_all("R10 reset");

        // R10: extended register 1 written before the base register
        apply("R10 emr1 first", 1, 1, 4'b0000, 3'd1, 16'h0018);

        // R4 R5: sweep every burst and latency code
        for (int cl = 0; cl < 8; cl++)
            for (int bl = 0; bl < 8; bl++)
                apply("R4 R5 mr sweep", 1, 1, 4'b0000, 3'd0, 16'((cl << 4) | bl));
        apply("R11 pulse end", 1, 1, 4'b0000, 3'd0, 16'h0032);
        nop("R11 idle");

        // R1: every non-write combination with a different payload
        for (int cmd = 1; cmd < 16; cmd++)
            apply("R1 not a write", 1, 1, 4'(cmd), 3'd0, 16'h0063);

        // R3: clock enable low or banks open, for each target
        for (int t = 0; t < 4; t++) begin
            apply("R3 cke low",  0, 1, 4'b0000, 3'(t), 16'h0053);
            apply("R3 bank open", 1, 0, 4'b0000, 3'(t), 16'h0053);
            apply("R3 both",      0, 0, 4'b0000, 3'(t), 16'h0053);
        end

        // R2: register 2 accepts base-register style content with no effect
        apply("R2 emr2", 1, 1, 4'b0000, 3'd2, 16'h0063);
        apply("R2 emr2", 1, 1, 4'b0000, 3'd2, 16'hFFFF);

        // R6 R8 R9: sweep calibration code, additive latency, strobe enable
        for (int r = 0; r < 2; r++)
            for (int oc = 0; oc < 8; oc++)
                for (int al = 0; al < 8; al++)
                    apply("R6 R8 R9 emr1 sweep", 1, 1, 4'b0000, 3'd1,
                          16'((r << 11) | (oc << 7) | (al << 3)));

        // R9: adjust forces 4 beats over a stored 8-beat length, keeps latency
        apply("R9 mr bl8",   1, 1, 4'b0000, 3'd0, 16'h0043);
        apply("R9 set al",   1, 1, 4'b0000, 3'd1, 16'h0028);
        apply("R9 adjust",   1, 1, 4'b0000, 3'd1, 16'h0210);
        apply("R9 exit",     1, 1, 4'b0000, 3'd1, 16'h0010);

        // R8: drive-high then drive-low patterns
        apply("R8 drive1", 1, 1, 4'b0000, 3'd1, 16'h0080);
        apply("R8 drive0", 1, 1, 4'b0000, 3'd1, 16'h0100);

        // R7: reserved bits in register 1
        for (int b = 13; b < 16; b++)
            apply("R7 emr1 reserved", 1, 1, 4'b0000, 3'd1, 16'((1 << b) | 16'h0818));
        apply("R7 emr1 ba2", 1, 1, 4'b0000, 3'd5, 16'h0818);

        // R7: register 3 accepts only all-zero content
        for (int b = 0; b < 16; b++)
            apply("R7 emr3 bit", 1, 1, 4'b0000, 3'd3, 16'(1 << b));
        apply("R7 emr3 ba2",  1, 1, 4'b0000, 3'd7, 16'd0);
        apply("R7 emr3 zero", 1, 1, 4'b0000, 3'd3, 16'd0);

        // R11: back-to-back refusals then idle
        apply("R11 err a", 1, 1, 4'b0000, 3'd0, 16'h0070);
        apply("R11 err b", 0, 1, 4'b0000, 3'd0, 16'h0032);
        nop("R11 drop");

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule